// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is the serial front end of a small sensor-style register file. It listens on an already synchronized two-wire clock and data pair and answers as a slave. A master can select one of four 16-bit registers through a pointer byte, write them one byte at a time, and read them back. The block keeps the pointer between transactions, so a master can read the same register again and again without rewriting the pointer. The only drive onto the bus is an open-drain pull-down enable for the data line.

The register storage sits outside the block. The slave shows the current pointer, takes the 16-bit content of the selected register, and gives out byte write strobes together with the byte written. It also gives a one-cycle pulse whenever a read is addressed to it, which the alert logic next door uses as a clear. Beside normal traffic, the slave handles the general-call reset command and the SMBus alert-response read, where it competes with other devices bit by bit. It recognises the high-speed master code and reports that mode without acknowledging it. If the clock line is held low for too long, it drops back to idle.

Top module: `tw_reg_slave`

## Requirements
- R1: The slave acknowledges a byte after START whose upper seven bits equal {ADDR_BASE (5'b10010), addr_sel_i}. A different non-reserved address is not acknowledged, and SDA is left released for the whole transaction.
- R2: In a write, the first byte after the address selects the register through its two low bits, which appear on reg_sel_o. The pointer keeps its value after STOP, so a read with no pointer write returns the register last selected. Reset sets the pointer to 0.
- R3: A read sends the selected register's upper byte and then its lower byte, each most significant bit first. rd_pulse_o pulses once when a read address is decoded.
- R4: Written data bytes give wr_hi_o for the first byte and wr_lo_o for the second, with wr_byte_o holding the data. A write stopped after one byte gives only wr_hi_o. Pointer 0 (temperature) gives no strobe at all, and the two strobes never fire together.
- R5: After the master answers a read byte with NACK, the slave keeps SDA released until the next START or STOP.
- R6: A general-call address byte 8'h00 is acknowledged. A following command byte 8'h06 is acknowledged, pulses gc_reset_o and sets the pointer to 0. Any other command byte is not acknowledged.
- R7: An alert-response read (byte 8'h19) is acknowledged only while alert_i is high. The slave then returns {own 7-bit address, alert_cause_i} and pulses alert_clr_o when the byte is complete.
- R8: During the alert response, if the slave releases SDA to send a 1 but samples 0 while SCL is high, it releases SDA for the rest of the byte and gives no alert_clr_o.
- R9: If SCL is sampled low for TIMEOUT_CYC consecutive cycles, the slave releases SDA and waits for a new START.
- R10: An address byte of the form 8'b00001xxx is not acknowledged and sets hs_mode_o. hs_mode_o stays high through repeated STARTs and clears at the next STOP.
- R11: A START or STOP in the middle of a byte abandons it. After a START the next byte is taken as a fresh address.
- R12: sda_oe_o only begins to pull SDA low after a cycle in which SCL was sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (bus level) |
| addr_sel_i | input | 2 | Low two address bits from the address-select strap |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_sel_o | output | 2 | Current register pointer |
| rd_data_i | input | 16 | Content of the register selected by reg_sel_o |
| wr_hi_o | output | 1 | Write strobe for the upper byte of the selected register |
| wr_lo_o | output | 1 | Write strobe for the lower byte of the selected register |
| wr_byte_o | output | 8 | Byte to write along with a strobe |
| rd_pulse_o | output | 1 | One-cycle pulse when a read address is decoded |
| alert_i | input | 1 | Alert is active and may answer an alert response |
| alert_cause_i | input | 1 | Bit returned after the address in the alert response |
| alert_clr_o | output | 1 | Pulse when the alert response was won |
| gc_reset_o | output | 1 | Pulse on a general-call reset command |
| hs_mode_o | output | 1 | High-speed master code seen, held until STOP |

## Verification
The master model reads after power-up, after pointer writes to each kind of register, and after one-byte and two-byte writes. This separates pointer retention from pointer reset and shows the byte order of both directions. Addresses are tried matching, not matching, general call, alert response with and without an alert pending, and high-speed code, so that each decode branch gives a different acknowledge. A competing device that pulls a lower address onto the bus during the alert response shows whether the slave backs off at the first lost bit. Aborted bytes, a master NACK and a clock held low check that the slave lets go of SDA on every exit path.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
   localparam int BYTE_W = 8;
   localparam int REG_W  = 2 * BYTE_W;
   localparam int PTR_W  = 2;

   localparam logic [6:0] ARA_ADDR   = 7'b0001100;
   localparam logic [7:0] GC_ADDR    = 8'h00;
   localparam logic [7:0] GC_RST_CMD = 8'h06;
   localparam logic [4:0] HS_PREFIX  = 5'b00001;

   typedef enum logic [2:0] {
      S_IDLE, S_RX, S_RXEND, S_ACK, S_TX, S_TXEND, S_MACK, S_MNEXT
   } st_t;

   typedef enum logic [2:0] {
      RL_ADDR, RL_PTR, RL_WDAT, RL_GCCMD, RL_RDREG, RL_ARA
   } role_t;
endpackage

// File: rtl/tw_line_events.sv
`timescale 1ns/1ps
module tw_line_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tw_scl_timeout.sv
`timescale 1ns/1ps
module tw_scl_timeout #(
   parameter int unsigned LIMIT = 3_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   output logic expired
);
   generate
      if (LIMIT == 0) begin : g_off
         assign expired = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(LIMIT + 1);
         logic [CW-1:0] low_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               low_cnt <= '0;
            else if (scl_i)
               low_cnt <= '0;
            else if (low_cnt != CW'(LIMIT))
               low_cnt <= low_cnt + 1'b1;
         end

         assign expired = ~scl_i && (low_cnt == CW'(LIMIT - 1));
      end
   endgenerate
endmodule

// File: rtl/tw_reg_slave.sv
`timescale 1ns/1ps
module tw_reg_slave
   import tw_pkg::*;
#(
   parameter logic [4:0]  ADDR_BASE   = 5'b10010,
   parameter int unsigned TIMEOUT_CYC = 3_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [1:0]        addr_sel_i,
   output logic              sda_oe_o,
   output logic [PTR_W-1:0]  reg_sel_o,
   input  logic [REG_W-1:0]  rd_data_i,
   output logic              wr_hi_o,
   output logic              wr_lo_o,
   output logic [BYTE_W-1:0] wr_byte_o,
   output logic              rd_pulse_o,
   input  logic              alert_i,
   input  logic              alert_cause_i,
   output logic              alert_clr_o,
   output logic              gc_reset_o,
   output logic              hs_mode_o
);
   generate
      if (ADDR_BASE[4:1] == 4'b0000 || ADDR_BASE[4:1] == 4'b1111) begin : g_bad_addr
         $error("ADDR_BASE falls in a reserved address group");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det, tmo;

   tw_line_events u_ev (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   tw_scl_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .expired(tmo)
   );

   st_t               st;
   role_t             role, nrole;
   logic [2:0]        bcnt;
   logic [6:0]        sh;
   logic [BYTE_W-1:0] tx, load_b, rx_b;
   logic              ack_q, tx_lo, w_lo, cause_q;
   logic [6:0]        own;

   assign own  = {ADDR_BASE, addr_sel_i};
   assign rx_b = {sh, sda_i};

   always_comb begin
      if (st == S_ACK && nrole == RL_ARA)
         load_b = {own, cause_q};
      else if (tx_lo)
         load_b = rd_data_i[BYTE_W-1:0];
      else
         load_b = rd_data_i[REG_W-1:BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;   role <= RL_ADDR;  nrole <= RL_ADDR;
         bcnt <= '0;     sh <= '0;         tx <= '0;
         ack_q <= 1'b0;  tx_lo <= 1'b0;    w_lo <= 1'b0;  cause_q <= 1'b0;
         sda_oe_o <= 1'b0;  reg_sel_o <= '0;  wr_byte_o <= '0;
         wr_hi_o <= 1'b0;   wr_lo_o <= 1'b0;  rd_pulse_o <= 1'b0;
         alert_clr_o <= 1'b0;  gc_reset_o <= 1'b0;  hs_mode_o <= 1'b0;
      end else begin
         wr_hi_o <= 1'b0;  wr_lo_o <= 1'b0;  rd_pulse_o <= 1'b0;
         alert_clr_o <= 1'b0;  gc_reset_o <= 1'b0;
         if (tmo) begin
            st <= S_IDLE;  sda_oe_o <= 1'b0;
         end else if (stop_det) begin
            st <= S_IDLE;  sda_oe_o <= 1'b0;  hs_mode_o <= 1'b0;
         end else if (start_det) begin
            st <= S_RX;  role <= RL_ADDR;  bcnt <= '0;  sda_oe_o <= 1'b0;
         end else begin
            unique case (st)
               S_RX: if (scl_rise) begin
                  sh   <= rx_b[6:0];
                  bcnt <= bcnt + 1'b1;
                  if (bcnt == 3'd7) begin
                     st <= S_RXEND;
                     ack_q <= 1'b0;
                     case (role)
                        RL_ADDR: begin
                           if (rx_b[7:1] == own) begin
                              ack_q <= 1'b1;
                              if (rx_b[0]) begin
                                 nrole <= RL_RDREG;  tx_lo <= 1'b0;  rd_pulse_o <= 1'b1;
                              end else begin
                                 nrole <= RL_PTR;
                              end
                           end else if (rx_b == GC_ADDR) begin
                              ack_q <= 1'b1;  nrole <= RL_GCCMD;
                           end else if (rx_b == {ARA_ADDR, 1'b1} && alert_i) begin
                              ack_q <= 1'b1;  nrole <= RL_ARA;  cause_q <= alert_cause_i;
                           end else if (rx_b[7:3] == HS_PREFIX) begin
                              hs_mode_o <= 1'b1;
                           end
                        end
                        RL_PTR: begin
                           ack_q <= 1'b1;  reg_sel_o <= rx_b[PTR_W-1:0];
                           nrole <= RL_WDAT;  w_lo <= 1'b0;
                        end
                        RL_WDAT: begin
                           ack_q <= 1'b1;  nrole <= RL_WDAT;  w_lo <= ~w_lo;
                           if (reg_sel_o != '0) begin
                              wr_byte_o <= rx_b;  wr_hi_o <= ~w_lo;  wr_lo_o <= w_lo;
                           end
                        end
                        RL_GCCMD: begin
                           if (rx_b == GC_RST_CMD) begin
                              ack_q <= 1'b1;  reg_sel_o <= '0;
                              gc_reset_o <= 1'b1;  nrole <= RL_GCCMD;
                           end
                        end
                        default: ack_q <= 1'b0;
                     endcase
                  end
               end
               S_RXEND: if (scl_fall) begin
                  if (ack_q) begin
                     sda_oe_o <= 1'b1;  st <= S_ACK;
                  end else begin
                     st <= S_IDLE;
                  end
               end
               S_ACK: if (scl_fall) begin
                  role <= nrole;  bcnt <= '0;
                  if (nrole == RL_RDREG || nrole == RL_ARA) begin
                     tx <= load_b;  sda_oe_o <= ~load_b[7];  st <= S_TX;
                     if (nrole == RL_RDREG) tx_lo <= ~tx_lo;
                  end else begin
                     sda_oe_o <= 1'b0;  st <= S_RX;
                  end
               end
               S_TX: begin
                  if (scl_rise) begin
                     if (role == RL_ARA && tx[7] && !sda_i) begin
                        sda_oe_o <= 1'b0;  st <= S_IDLE;
                     end else begin
                        tx   <= {tx[6:0], 1'b0};
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == 3'd7) st <= S_TXEND;
                     end
                  end else if (scl_fall) begin
                     sda_oe_o <= ~tx[7];
                  end
               end
               S_TXEND: if (scl_fall) begin
                  sda_oe_o <= 1'b0;  st <= S_MACK;
                  if (role == RL_ARA) alert_clr_o <= 1'b1;
               end
               S_MACK: if (scl_rise) begin
                  if (sda_i || role == RL_ARA) st <= S_IDLE;
                  else st <= S_MNEXT;
               end
               S_MNEXT: if (scl_fall) begin
                  tx <= load_b;  sda_oe_o <= ~load_b[7];
                  tx_lo <= ~tx_lo;  bcnt <= '0;  st <= S_TX;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/tw_reg_slave_chk.sv
`timescale 1ns/1ps
module tw_reg_slave_chk #(
   parameter int unsigned TIMEOUT_CYC = 3_000_000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_i,
   input logic       sda_oe_o,
   input logic [1:0] reg_sel_o,
   input logic       wr_hi_o,
   input logic       wr_lo_o,
   input logic       gc_reset_o,
   input logic       hs_mode_o
);
   logic [31:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            low_run <= '0;
      else if (scl_i)        low_run <= '0;
      else if (low_run != '1) low_run <= low_run + 1'b1;
   end

   AST_PULL_IN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !$past(scl_i)); // R12

   AST_STOP_LEAVES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe_o); // R11

   AST_TEMP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_o || wr_lo_o) |-> (reg_sel_o != 2'b00)); // R4

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_hi_o, wr_lo_o})); // R4

   AST_GC_POINTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      gc_reset_o |-> (reg_sel_o == 2'b00)); // R6

   AST_HS_UNACKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_mode_o) |-> !sda_oe_o); // R10

   AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (TIMEOUT_CYC != 0 && !scl_i && low_run >= TIMEOUT_CYC) |-> !sda_oe_o); // R9
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
   .sda_oe_o(sda_oe_o), .reg_sel_o(reg_sel_o),
   .wr_hi_o(wr_hi_o), .wr_lo_o(wr_lo_o),
   .gc_reset_o(gc_reset_o), .hs_mode_o(hs_mode_o)
);

// File: tb/tb_tw_reg_slave.sv
`timescale 1ns/1ps
module tb_tw_reg_slave;
   localparam int TMO = 200;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1, comp_pull = 1'b0;
   logic alert = 1'b0, cause = 1'b0;
   logic [1:0] sel = 2'b01;
   logic sda_bus, sda_oe, wr_hi, wr_lo, rd_pulse, alert_clr, gc_reset, hs_mode;
   logic [1:0] reg_sel;
   logic [7:0] wr_byte;
   logic [15:0] rd_data;
   logic [15:0] regs [4];

   assign sda_bus = m_sda & ~sda_oe & ~comp_pull;
   assign rd_data = regs[reg_sel];

   tw_reg_slave #(.TIMEOUT_CYC(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .addr_sel_i(sel), .sda_oe_o(sda_oe), .reg_sel_o(reg_sel),
      .rd_data_i(rd_data), .wr_hi_o(wr_hi), .wr_lo_o(wr_lo),
      .wr_byte_o(wr_byte), .rd_pulse_o(rd_pulse), .alert_i(alert),
      .alert_cause_i(cause), .alert_clr_o(alert_clr),
      .gc_reset_o(gc_reset), .hs_mode_o(hs_mode)
   );

   int errors = 0, checks = 0;
   int hi_cnt = 0, lo_cnt = 0, rdp_cnt = 0, clr_cnt = 0, gc_cnt = 0, viol = 0;
   logic scl_p = 1'b1, oe_p = 1'b0;
   bit done = 1'b0;

   task automatic load_defaults();
      regs[0] = 16'h1900; regs[1] = 16'h60A0; regs[2] = 16'h4B00; regs[3] = 16'h5000;
   endtask

   initial load_defaults();

   // neighbour register file and event counters, sampled between edges
   always begin
      @(posedge clk); #1;
      if (wr_hi) begin hi_cnt++; regs[reg_sel][15:8] = wr_byte; end
      if (wr_lo) begin lo_cnt++; regs[reg_sel][7:0]  = wr_byte; end
      if (rd_pulse)  rdp_cnt++;
      if (alert_clr) clr_cnt++;
      if (gc_reset) begin gc_cnt++; load_defaults(); end
      if (rst_n && m_scl && scl_p && sda_oe && !oe_p) viol++;
      scl_p = m_scl;
      oe_p  = sda_oe;
   end

   // scoreboard
   string exp_tag[$];
   int    exp_val[$];
   int    obs_val[$];

   task automatic push_exp(string tag, int v);
      exp_tag.push_back(tag); exp_val.push_back(v);
   endtask
   task automatic push_obs(int v);
      obs_val.push_back(v);
   endtask
   task automatic chk(string tag, int act, int exp);
      push_exp(tag, exp); push_obs(act);
   endtask

   always begin
      @(negedge clk);
      while (obs_val.size() > 0 && exp_val.size() > 0) begin
         int a, e;
         string t;
         a = obs_val.pop_front(); e = exp_val.pop_front(); t = exp_tag.pop_front();
         checks++;
         if (a != e) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", t, a, e);
         end
      end
   end

   // bus master driver
   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic bit_put(input logic b);
      m_sda = b; wait_clk(3); m_scl = 1'b1; wait_clk(6); m_scl = 1'b0; wait_clk(3);
   endtask
   task automatic bit_get(output logic b);
      m_sda = 1'b1; wait_clk(3); m_scl = 1'b1; wait_clk(3); b = sda_bus;
      wait_clk(3); m_scl = 1'b0; wait_clk(3);
   endtask
   task automatic bus_start();
      m_sda = 1'b1; wait_clk(3); m_scl = 1'b1; wait_clk(3); m_sda = 1'b0;
      wait_clk(3); m_scl = 1'b0; wait_clk(3);
   endtask
   task automatic bus_stop();
      m_sda = 1'b0; wait_clk(3); m_scl = 1'b1; wait_clk(3); m_sda = 1'b1; wait_clk(4);
   endtask
   task automatic wbyte(input logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) bit_put(d[i]);
      bit_get(ack);
   endtask
   task automatic rbyte(output logic [7:0] d, input logic nack, input logic [7:0] comp);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         comp_pull = ~comp[i];
         bit_get(b);
         d[i] = b;
      end
      comp_pull = 1'b0;
      bit_put(nack);
   endtask

   initial begin
      logic a;
      logic [7:0] d;
      wait_clk(5); rst_n = 1'b1; wait_clk(3);

      chk("R2 pointer after reset", reg_sel, 0);
      chk("R12 released after reset", sda_oe, 0);
      chk("R10 hs low after reset", hs_mode, 0);

      // read with no pointer write
      bus_start(); wbyte(8'h93, a); chk("R1 own read address acked", a, 0);
      rbyte(d, 1'b0, 8'hFF); chk("R3 upper byte first", d, 8'h19);
      rbyte(d, 1'b1, 8'hFF); chk("R3 lower byte second", d, 8'h00);
      bus_stop(); chk("R3 one read pulse", rdp_cnt, 1);

      bus_start(); wbyte(8'h91, a); chk("R1 foreign address not acked", a, 1);
      bus_stop();

      // pointer + two-byte write
      bus_start(); wbyte(8'h92, a); chk("R1 own write address acked", a, 0);
      wbyte(8'h01, a); chk("R2 pointer byte acked", a, 0);
      wbyte(8'h12, a); wbyte(8'h34, a); bus_stop();
      chk("R4 upper strobe count", hi_cnt, 1);
      chk("R4 lower strobe count", lo_cnt, 1);
      chk("R2 pointer shown", reg_sel, 1);
      bus_start(); wbyte(8'h93, a);
      rbyte(d, 1'b0, 8'hFF); chk("R2 retained pointer upper", d, 8'h12);
      rbyte(d, 1'b1, 8'hFF); chk("R2 retained pointer lower", d, 8'h34);
      bus_stop();

      // single-byte write
      bus_start(); wbyte(8'h92, a); wbyte(8'h02, a); wbyte(8'hAB, a); bus_stop();
      chk("R4 one-byte write upper strobes", hi_cnt, 2);
      chk("R4 one-byte write no lower strobe", lo_cnt, 1);
      bus_start(); wbyte(8'h93, a);
      rbyte(d, 1'b0, 8'hFF); chk("R4 upper byte replaced", d, 8'hAB);
      rbyte(d, 1'b1, 8'hFF); chk("R4 lower byte kept", d, 8'h00);
      bus_stop();

      // temperature register is read only
      bus_start(); wbyte(8'h92, a); wbyte(8'h00, a); wbyte(8'h55, a); wbyte(8'h66, a); bus_stop();
      chk("R4 no upper strobe on pointer 0", hi_cnt, 2);
      chk("R4 no lower strobe on pointer 0", lo_cnt, 1);

      // master NACK
      bus_start(); wbyte(8'h93, a);
      rbyte(d, 1'b1, 8'hFF); chk("R5 byte before NACK", d, 8'h19);
      rbyte(d, 1'b1, 8'hFF); chk("R5 released after NACK", d, 8'hFF);
      bus_stop();

      // general call
      bus_start(); wbyte(8'h92, a); wbyte(8'h03, a); bus_stop();
      chk("R2 pointer set to 3", reg_sel, 3);
      bus_start(); wbyte(8'h00, a); chk("R6 general call acked", a, 0);
      wbyte(8'h06, a); chk("R6 reset command acked", a, 0); bus_stop();
      chk("R6 reset pulse", gc_cnt, 1);
      chk("R6 pointer cleared", reg_sel, 0);
      bus_start(); wbyte(8'h00, a); wbyte(8'h04, a); chk("R6 other command not acked", a, 1);
      bus_stop(); chk("R6 no extra reset pulse", gc_cnt, 1);

      // alert response
      bus_start(); wbyte(8'h19, a); chk("R7 no answer without alert", a, 1); bus_stop();
      alert = 1'b1; cause = 1'b1;
      bus_start(); wbyte(8'h19, a); chk("R7 alert response acked", a, 0);
      rbyte(d, 1'b1, 8'hFF); chk("R7 returned address and cause", d, 8'h93);
      bus_stop(); chk("R7 alert cleared on win", clr_cnt, 1);

      cause = 1'b0;
      bus_start(); wbyte(8'h19, a);
      rbyte(d, 1'b1, 8'h91); chk("R8 backs off after lost bit", d, 8'h91);
      bus_stop(); chk("R8 no clear on loss", clr_cnt, 1);
      alert = 1'b0;

      // SCL held low
      bus_start(); wbyte(8'h93, a);
      chk("R9 driving before timeout", sda_oe, 1);
      wait_clk(TMO + 10);
      chk("R9 released after timeout", sda_oe, 0);
      bus_start(); wbyte(8'h92, a); chk("R9 new START accepted", a, 0); bus_stop();

      // high-speed master code
      bus_start(); wbyte(8'h08, a); chk("R10 master code not acked", a, 1);
      chk("R10 hs flag set", hs_mode, 1);
      bus_start(); wbyte(8'h93, a); chk("R10 address after master code", a, 0);
      rbyte(d, 1'b1, 8'hFF); chk("R10 hs held over repeated START", hs_mode, 1);
      bus_stop(); chk("R10 hs cleared at STOP", hs_mode, 0);

      // aborted bytes
      bus_start(); bit_put(1'b1); bit_put(1'b0); bit_put(1'b1);
      bus_start(); wbyte(8'h93, a); chk("R11 START mid-byte restarts address", a, 0);
      rbyte(d, 1'b1, 8'hFF); bus_stop();
      bus_start(); bit_put(1'b1); bit_put(1'b0); bus_stop();
      bus_start(); wbyte(8'h92, a); chk("R11 STOP mid-byte then new address", a, 0);
      bus_stop();

      chk("R12 no pull-down begun while SCL high", viol, 0);

      wait_clk(10);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule